// File: doc/BRIEF.md
# Serial/Parallel FIFO Output Register

This block sits below the bottom slot of a fall-through word stack. It takes one word at a time from that slot and makes it available to the reader in two ways: the whole word on a parallel bus, or bit by bit, least significant bit first, on a single serial pin. An output-valid flag carries the handshake. A reader that holds the parallel transfer request HIGH receives a word, and lowering the request marks that word as consumed. For serial reading, the valid flag can be wired back to the active-low serial request so that the next word is fetched as soon as the previous one has been shifted out.

Several slices can sit side by side to form a wider word. One slice is the lead slice, and the others follow it. Which role a slice takes is decided during master reset by the `lead_n` strap: LOW makes the slice the lead. A following slice loads its word but holds its valid flag LOW until its chain input `chain_en` goes HIGH. This lets the valid flag of the last slice in a row mark the moment the whole row is ready. The whole block runs on one clock. The serial output clock is an ordinary input whose falling edges are detected against that clock. Tri-state pins are modelled as a data value plus an enable.

The controller has three states. ST_EMPTY means no unread word is held. ST_PEND means a following slice holds a word but is still waiting for its chain input. ST_FULL means the word is valid. The transitions are: take (ST_EMPTY to ST_FULL, or to ST_PEND when the slice follows and `chain_en` is LOW), release (ST_PEND to ST_FULL when `chain_en` is HIGH), drop (ST_FULL to ST_EMPTY when `xfer_par` goes LOW) and drain (ST_FULL to ST_EMPTY on the falling edge of `ser_clk` that shifts out the last bit).

Top module: `sfifo_outreg`

## Requirements
- R1: While `mr_n` is LOW and in the first cycle after it is released, `out_valid` and `q_ser_en` are LOW, and `stk_take` stays LOW while the stack is empty.
- R2: In ST_EMPTY, with `xfer_par` HIGH, `xfer_ser_n` LOW and `stk_valid` HIGH, `stk_take` pulses for one cycle. For a lead slice, `out_valid` is HIGH from the next cycle and `q_par` equals the word that was taken.
- R3: A word is taken only once. While `xfer_par` stays HIGH after a take, no further `stk_take` occurs and `q_par` keeps its value, even if the stack holds more words.
- R4: `xfer_par` acts as a level. A word that reaches the stack bottom while `xfer_par` is already HIGH is taken on the next clock.
- R5: When `xfer_par` goes LOW, `out_valid` is LOW from the next cycle, but `q_par` keeps the old word until the next take. A HIGH pulse on `xfer_par` while the stack is empty leaves `out_valid` LOW and takes nothing.
- R6: After a take, `q_ser_en` is HIGH while `out_valid` is HIGH, and `q_ser` shows bit 0 of the word.
- R7: Each falling edge of `ser_clk` seen while valid shifts the next higher bit onto `q_ser`. A HIGH level alone does not shift. On the falling edge that shifts out bit 3, `out_valid` and `q_ser_en` both go LOW.
- R8: While `xfer_ser_n` is HIGH, no word is taken even if `xfer_par` and `stk_valid` are HIGH. Once `xfer_ser_n` goes LOW, the take goes ahead.
- R9: A slice reset with `lead_n` HIGH takes the word but keeps `out_valid` LOW until `chain_en` is HIGH. `out_valid` then rises on the next clock.
- R10: `q_par_en` is HIGH exactly when `oe` is HIGH.
- R11: With `xfer_ser_n` driven from `out_valid` and `xfer_par` held HIGH, the serial stream reproduces every word in stack order, least significant bit first, with no word repeated or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mr_n | input | 1 | Master reset, active LOW, synchronous |
| lead_n | input | 1 | Sampled during reset. LOW makes this slice the lead slice |
| stk_word | input | W | Word at the stack bottom |
| stk_valid | input | 1 | Stack bottom holds a word |
| stk_take | output | 1 | One-cycle pulse that removes the bottom word |
| xfer_par | input | 1 | Parallel transfer request, level-sensitive |
| xfer_ser_n | input | 1 | Serial transfer request, active LOW |
| ser_clk | input | 1 | Serial output clock. Falling edges shift |
| chain_en | input | 1 | Output-side chain input from the slice ahead |
| oe | input | 1 | Parallel output enable |
| q_par | output | W | Parallel data |
| q_par_en | output | 1 | Drive enable for `q_par` |
| q_ser | output | 1 | Serial data |
| q_ser_en | output | 1 | Drive enable for `q_ser` |
| out_valid | output | 1 | Output-valid flag |

## Verification
The bench holds `xfer_par` HIGH across several cycles while the stack still has words, so a design that treated the request as a pure level without a guard would take a second word and overwrite `q_par`. It raises the request before any word exists and then pulses it over an empty stack; an edge-triggered design would miss the late word, and a careless one would raise valid with nothing loaded. It counts the shifts to the exact cycle, so a marker placed one bit off would drop valid after three shifts or after five. With the feedback wiring it streams several words, which would reveal any repeated or lost word at a drain boundary. A following slice is reset and held off by its chain input; a design that skipped this interlock would raise valid early.

// File: rtl/outreg_pkg.sv
package outreg_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PEND  = 2'd1,
        ST_FULL  = 2'd2
    } orst_e;

endpackage

// File: rtl/outreg_edge.sv
module outreg_edge (
    input  logic clk,
    input  logic mr_n,
    input  logic din,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (!mr_n) prev_q <= 1'b0;
        else       prev_q <= din;
    end

    assign fall = prev_q & ~din;

endmodule

// File: rtl/outreg_data.sv
module outreg_data #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] q_par,
    output logic         ser_bit,
    output logic         last_shift
);

    // shift register one bit wider than the word: a marker bit sits above the data
    localparam int SW = W + 1;

    logic [SW-1:0] sh_q;
    logic [W-1:0]  par_q;

    always_ff @(posedge clk) begin
        if (!mr_n) begin
            sh_q  <= '0;
            par_q <= '0;
        end else if (load) begin
            sh_q  <= {1'b1, din};
            par_q <= din;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[SW-1:1]};
        end
    end

    assign q_par      = par_q;
    assign ser_bit    = sh_q[0];
    // the marker has reached bit 1: the coming shift sends out the final data bit
    assign last_shift = sh_q[1] && (sh_q[SW-1:2] == '0);

endmodule

// File: rtl/outreg_ctrl.sv
module outreg_ctrl
    import outreg_pkg::*;
(
    input  logic clk,
    input  logic mr_n,
    input  logic lead_n,
    input  logic xfer_par,
    input  logic xfer_ser_n,
    input  logic stk_valid,
    input  logic chain_en,
    input  logic shift_fall,
    input  logic last_shift,
    output logic load,
    output logic shift,
    output logic valid,
    output logic ser_en,
    output logic master
);

    orst_e state_q, state_d;
    logic  master_q;
    logic  req;

    assign req = xfer_par && !xfer_ser_n && stk_valid;

    always_ff @(posedge clk) begin
        if (!mr_n) master_q <= !lead_n;
    end

    always_ff @(posedge clk) begin
        if (!mr_n) state_q <= ST_EMPTY;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (req) state_d = (master_q || chain_en) ? ST_FULL : ST_PEND;
            end
            ST_PEND: begin
                if (chain_en) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (!xfer_par)                     state_d = ST_EMPTY;
                else if (shift_fall && last_shift) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        load   = 1'b0;
        shift  = 1'b0;
        valid  = 1'b0;
        ser_en = 1'b0;
        unique case (state_q)
            ST_EMPTY: load = req;
            ST_PEND:  ;
            ST_FULL: begin
                valid  = 1'b1;
                ser_en = 1'b1;
                shift  = shift_fall;
            end
            default: ;
        endcase
    end

    assign master = master_q;

endmodule

// File: rtl/sfifo_outreg.sv
module sfifo_outreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic         lead_n,
    input  logic [W-1:0] stk_word,
    input  logic         stk_valid,
    output logic         stk_take,
    input  logic         xfer_par,
    input  logic         xfer_ser_n,
    input  logic         ser_clk,
    input  logic         chain_en,
    input  logic         oe,
    output logic [W-1:0] q_par,
    output logic         q_par_en,
    output logic         q_ser,
    output logic         q_ser_en,
    output logic         out_valid
);

    logic sclk_fall;
    logic load_w;
    logic shift_w;
    logic last_w;
    logic master_q;

    outreg_edge u_edge (
        .clk  (clk),
        .mr_n (mr_n),
        .din  (ser_clk),
        .fall (sclk_fall)
    );

    outreg_ctrl u_ctrl (
        .clk        (clk),
        .mr_n       (mr_n),
        .lead_n     (lead_n),
        .xfer_par   (xfer_par),
        .xfer_ser_n (xfer_ser_n),
        .stk_valid  (stk_valid),
        .chain_en   (chain_en),
        .shift_fall (sclk_fall),
        .last_shift (last_w),
        .load       (load_w),
        .shift      (shift_w),
        .valid      (out_valid),
        .ser_en     (q_ser_en),
        .master     (master_q)
    );

    outreg_data #(.W(W)) u_data (
        .clk        (clk),
        .mr_n       (mr_n),
        .load       (load_w),
        .shift      (shift_w),
        .din        (stk_word),
        .q_par      (q_par),
        .ser_bit    (q_ser),
        .last_shift (last_w)
    );

    assign stk_take = load_w;
    assign q_par_en = oe;

endmodule

// File: rtl/outreg_chk.sv
module outreg_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         mr_n,
    input logic         xfer_par,
    input logic         chain_en,
    input logic         is_master,
    input logic         stk_valid,
    input logic         stk_take,
    input logic         out_valid,
    input logic         q_ser_en,
    input logic [W-1:0] q_par
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!mr_n)
        $past(!mr_n) |-> (!out_valid && !q_ser_en)); // R1

    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!mr_n)
        stk_take |-> (stk_valid && !out_valid)); // R2

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!mr_n)
        stk_take |=> !stk_take); // R3

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!mr_n)
        (out_valid && !xfer_par) |=> !out_valid); // R5

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!mr_n)
        !stk_take |=> $stable(q_par)); // R5

    AST_SLAVE_WAIT: assert property (@(posedge clk) disable iff (!mr_n)
        $rose(out_valid) |-> (is_master || $past(chain_en))); // R9

endmodule

bind sfifo_outreg outreg_chk #(.W(W)) u_chk (
    .clk       (clk),
    .mr_n      (mr_n),
    .xfer_par  (xfer_par),
    .chain_en  (chain_en),
    .is_master (master_q),
    .stk_valid (stk_valid),
    .stk_take  (stk_take),
    .out_valid (out_valid),
    .q_ser_en  (q_ser_en),
    .q_par     (q_par)
);

// File: tb/sfifo_outreg_tb_top.sv
`timescale 1ns/100ps
module sfifo_outreg_tb_top;

    localparam int W = 4;
    localparam int NV = 8;
    // each entry: {word[3:0], oe}; expected q_par = word, q_par_en = oe
    localparam logic [4:0] VECS [NV] = '{
        5'b0101_1, 5'b1010_0, 5'b0000_1, 5'b1111_1,
        5'b0011_0, 5'b1100_1, 5'b1001_0, 5'b0110_1
    };

    logic         clk = 1'b0;
    logic         mr_n = 1'b0;
    logic         lead_n = 1'b0;
    logic [W-1:0] stk_word = '0;
    logic         stk_valid = 1'b0;
    logic         stk_take;
    logic         xfer_par = 1'b0;
    logic         ser_n_drv = 1'b0;
    logic         fb_mode = 1'b0;
    logic         xfer_ser_n;
    logic         ser_clk = 1'b0;
    logic         chain_en = 1'b0;
    logic         oe = 1'b0;
    logic [W-1:0] q_par;
    logic         q_par_en;
    logic         q_ser;
    logic         q_ser_en;
    logic         out_valid;

    logic [W-1:0] stk_q[$];
    int           take_cnt = 0;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    assign xfer_ser_n = fb_mode ? out_valid : ser_n_drv;

    always #2.5 clk = ~clk;

    sfifo_outreg #(.W(W)) dut_i (
        .clk        (clk),
        .mr_n       (mr_n),
        .lead_n     (lead_n),
        .stk_word   (stk_word),
        .stk_valid  (stk_valid),
        .stk_take   (stk_take),
        .xfer_par   (xfer_par),
        .xfer_ser_n (xfer_ser_n),
        .ser_clk    (ser_clk),
        .chain_en   (chain_en),
        .oe         (oe),
        .q_par      (q_par),
        .q_par_en   (q_par_en),
        .q_ser      (q_ser),
        .q_ser_en   (q_ser_en),
        .out_valid  (out_valid)
    );

    task automatic refresh();
        stk_valid = (stk_q.size() != 0);
        stk_word  = stk_valid ? stk_q[0] : '0;
    endtask

    task automatic push_word(input logic [W-1:0] w);
        stk_q.push_back(w);
        refresh();
    endtask

    task automatic tick();
        logic took;
        @(negedge clk);
        took = stk_take;
        @(posedge clk);
        #1;
        if (took) begin
            void'(stk_q.pop_front());
            take_cnt++;
            refresh();
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic lead);
        mr_n = 1'b0;
        lead_n = lead;
        xfer_par = 1'b0;
        ser_n_drv = 1'b0;
        fb_mode = 1'b0;
        ser_clk = 1'b0;
        chain_en = 1'b0;
        stk_q.delete();
        refresh();
        repeat (3) tick();
        mr_n = 1'b1;
        take_cnt = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [W-1:0] wrd;
        logic         bits[$];
        logic [W-1:0] words [6];

        // R1 reset state
        do_reset(1'b0);
        check(!out_valid, "R1 valid after reset", out_valid, 0);
        check(!q_ser_en, "R1 serial enable after reset", q_ser_en, 0);
        tick();
        check(!stk_take && !out_valid, "R1 quiet first cycle", out_valid, 0);

        // table: R2, R3, R5, R10 over several words
        for (int i = 0; i < NV; i++) push_word(VECS[i][4:1]);
        for (int i = 0; i < NV; i++) begin
            wrd = VECS[i][4:1];
            oe = VECS[i][0];
            xfer_par = 1'b1;
            tick();
            check(out_valid, "R2 valid after take", out_valid, 1);
            check(q_par == wrd, "R2 word on bus", q_par, wrd);
            check(q_par_en == oe, "R10 bus enable follows oe", q_par_en, oe);
            check(take_cnt == i + 1, "R2 one take", take_cnt, i + 1);
            tick();
            tick();
            check(take_cnt == i + 1, "R3 no second take", take_cnt, i + 1);
            check(q_par == wrd && out_valid, "R3 word held", q_par, wrd);
            xfer_par = 1'b0;
            tick();
            check(!out_valid, "R5 valid drops", out_valid, 0);
            check(q_par == wrd, "R5 old word kept", q_par, wrd);
        end

        // R5 pulse over an empty stack
        xfer_par = 1'b1;
        tick();
        xfer_par = 1'b0;
        tick();
        check(!out_valid, "R5 empty pulse no valid", out_valid, 0);
        check(take_cnt == NV, "R5 empty pulse no take", take_cnt, NV);
        check(q_par == 4'h6, "R5 bus unchanged", q_par, 6);

        // R4 word arrives while request already HIGH
        xfer_par = 1'b1;
        tick();
        tick();
        check(!out_valid, "R4 nothing before arrival", out_valid, 0);
        push_word(4'h7);
        tick();
        check(out_valid && q_par == 4'h7, "R4 late word taken", q_par, 7);
        xfer_par = 1'b0;
        tick();

        // R8 serial request HIGH blocks the take
        push_word(4'h2);
        ser_n_drv = 1'b1;
        xfer_par = 1'b1;
        tick();
        tick();
        check(!out_valid && stk_q.size() == 1, "R8 blocked", out_valid, 0);
        ser_n_drv = 1'b0;
        tick();
        check(out_valid && q_par == 4'h2, "R8 resumes", q_par, 2);
        xfer_par = 1'b0;
        tick();

        // R6, R7 serial unload of 4'b1011
        push_word(4'b1011);
        xfer_par = 1'b1;
        tick();
        check(q_ser_en, "R6 serial enabled", q_ser_en, 1);
        check(q_ser == 1'b1, "R6 first bit", q_ser, 1);
        ser_clk = 1'b1;
        tick();
        check(q_ser == 1'b1 && out_valid, "R7 high level no shift", q_ser, 1);
        ser_clk = 1'b0;
        tick();
        check(q_ser == 1'b1, "R7 bit1", q_ser, 1);
        ser_clk = 1'b1;
        tick();
        ser_clk = 1'b0;
        tick();
        check(q_ser == 1'b0, "R7 bit2", q_ser, 0);
        ser_clk = 1'b1;
        tick();
        ser_clk = 1'b0;
        tick();
        check(q_ser == 1'b1 && out_valid, "R7 bit3 still valid", q_ser, 1);
        ser_clk = 1'b1;
        tick();
        ser_clk = 1'b0;
        tick();
        check(!out_valid && !q_ser_en, "R7 fourth shift empties", out_valid, 0);
        xfer_par = 1'b0;
        tick();

        // R9 following slice waits for chain input
        do_reset(1'b1);
        push_word(4'hD);
        xfer_par = 1'b1;
        tick();
        check(!out_valid && take_cnt == 1, "R9 taken but held", out_valid, 0);
        tick();
        tick();
        check(!out_valid, "R9 still held", out_valid, 0);
        chain_en = 1'b1;
        tick();
        check(out_valid && q_par == 4'hD, "R9 released", q_par, 13);
        xfer_par = 1'b0;
        chain_en = 1'b0;
        tick();

        // R11 serial stream with valid fed back to the serial request
        do_reset(1'b0);
        words = '{4'h1, 4'hE, 4'h5, 4'h8, 4'h3, 4'hC};
        for (int i = 0; i < 6; i++) push_word(words[i]);
        fb_mode = 1'b1;
        xfer_par = 1'b1;
        for (int c = 0; c < 200 && bits.size() < 24; c++) begin
            if (q_ser_en) begin
                bits.push_back(q_ser);
                ser_clk = 1'b1;
                tick();
                ser_clk = 1'b0;
                tick();
            end else begin
                tick();
            end
        end
        check(bits.size() == 24, "R11 bit count", bits.size(), 24);
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] got;
            got = '0;
            for (int b = 0; b < W; b++)
                if (bits.size() > i * W + b) got[b] = bits[i * W + b];
            check(got == words[i], "R11 word order", got, words[i]);
        end
        tick();
        tick();
        check(take_cnt == 6, "R11 no extra take", take_cnt, 6);
        check(!out_valid && !q_ser_en, "R11 drained", out_valid, 0);

        done = 1'b1;
        summary();
    end

endmodule